// File: doc/BRIEF.md
# Loss-of-Stream Audio Mute Controller

This block sits on the decoded audio path of a digital audio receiver, after clock and data recovery. It passes a pair of 24-bit channel samples from input to output on every frame strobe while an input stream is present. It also reports stream presence and lock status, and it pulses an event on each change of those two conditions.

When the stream disappears, the output depends on the kind of data that was flowing. For linear PCM, each channel starts from its own last valid sample and falls linearly to exactly zero over 4096 frames. For non-PCM (compressed) data, both outputs go to zero at once. After the stream comes back, the outputs stay muted until lock is reported again. Live samples then pass from the next frame strobe onward. The frame strobe comes from a local timebase and keeps running while the stream is absent.

Top module: `stream_mute_ctrl`

## Requirements
- R1: While reset is held, both sample outputs are 0, `nostream_o` is 1, `lock_o` is 0, and all three event outputs are 0.
- R2: In the live state, at each clock edge where `frame_stb` is high, the output captures `samp_a_i` and `samp_b_i`. Between strobes the outputs hold their values.
- R3: `lock_o` is 1 at the edge after an edge where both `stream_ok` and `lock_in` are 1, and 0 otherwise. `lock_evt_o` pulses for one cycle at each change of `lock_o`, and losing the stream clears `lock_o`.
- R4: Let L be the last passed sample of a channel, with `non_audio` at 0 on that last live frame. After k strobes of the ramp, that channel outputs floor(L*(4096-k)/4096). The output reaches 0 exactly on the 4096th strobe and then stays at 0.
- R5: If `non_audio` was 1 on the last live frame, both outputs become 0 at the first edge that samples `stream_ok` low, and they stay at 0.
- R6: `loss_evt_o` pulses for one cycle at the edge after the first edge that samples `stream_ok` low. `ret_evt_o` pulses the same way on return, and `nostream_o` follows the inverse of `stream_ok` one edge later.
- R7: If the stream returns during the ramp without lock, the ramp continues and sample inputs are ignored. Once `lock_o` is 1, the block returns to live at the next edge, and the next strobe passes live samples.
- R8: The two channels ramp independently, each from its own last sample and with its own sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame strobe from the local timebase |
| stream_ok | input | 1 | High while an input stream is present |
| lock_in | input | 1 | Lock indication from clock recovery |
| non_audio | input | 1 | High when the frame carries non-PCM data |
| samp_a_i | input | 24 | Channel A sample, two's complement |
| samp_b_i | input | 24 | Channel B sample, two's complement |
| samp_a_o | output | 24 | Channel A muted sample |
| samp_b_o | output | 24 | Channel B muted sample |
| nostream_o | output | 1 | No-stream status |
| lock_o | output | 1 | Lock status |
| loss_evt_o | output | 1 | Stream-loss event pulse |
| ret_evt_o | output | 1 | Stream-return event pulse |
| lock_evt_o | output | 1 | Lock-change event pulse |

## Verification
The assertions assume that `stream_ok`, `lock_in` and the samples are synchronous to `clk`. They also assume that `frame_stb` is a single-cycle pulse that keeps arriving while the stream is absent, so that the ramp can finish. The monotonic-ramp property further assumes that the output equals the last captured sample when the ramp starts. The stimulus meets these assumptions: it changes every input on the falling clock edge, it raises the strobe for exactly one cycle, and it always passes at least one live frame before it removes the stream.

// File: rtl/stream_mute_pkg.sv
package stream_mute_pkg;
  typedef enum logic [1:0] {
    ST_LIVE   = 2'd0,
    ST_FADE   = 2'd1,
    ST_SILENT = 2'd2
  } mute_st_e;

  typedef struct packed {
    logic pass_en;
    logic fade_load;
    logic fade_step;
    logic fade_last;
    logic force_zero;
  } chan_ctl_t;
endpackage

// File: rtl/mute_seq.sv
module mute_seq
  import stream_mute_pkg::*;
#(
  parameter int FADE_LOG2 = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_stb,
  input  logic      stream_ok,
  input  logic      lock_in,
  input  logic      non_audio,
  output chan_ctl_t ctl,
  output logic      nostream_o,
  output logic      lock_o,
  output logic      loss_evt_o,
  output logic      ret_evt_o,
  output logic      lock_evt_o
);
  mute_st_e st_q, st_d;
  logic [FADE_LOG2-1:0] cnt_q, cnt_d;
  logic type_q, type_d;
  logic nostream_q, lock_q, loss_q, ret_q, lkev_q;
  logic lock_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    type_d = type_q;
    ctl    = '0;
    unique case (st_q)
      ST_LIVE: begin
        if (!stream_ok) begin
          if (type_q) begin
            st_d           = ST_SILENT;
            ctl.force_zero = 1'b1;
          end else begin
            st_d          = ST_FADE;
            ctl.fade_load = 1'b1;
            cnt_d         = '0;
          end
        end else if (frame_stb) begin
          ctl.pass_en = 1'b1;
          type_d      = non_audio;
        end
      end
      ST_FADE: begin
        if (lock_q) begin
          st_d = ST_LIVE;
        end else if (frame_stb) begin
          ctl.fade_step = 1'b1;
          cnt_d         = cnt_q + 1'b1;
          if (cnt_q == '1) begin
            ctl.fade_last = 1'b1;
            st_d          = ST_SILENT;
          end
        end
      end
      default: begin
        ctl.force_zero = 1'b1;
        if (lock_q) st_d = ST_LIVE;
      end
    endcase
  end

  assign lock_d = stream_ok & lock_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_SILENT;
      cnt_q      <= '0;
      type_q     <= 1'b0;
      nostream_q <= 1'b1;
      lock_q     <= 1'b0;
      loss_q     <= 1'b0;
      ret_q      <= 1'b0;
      lkev_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      type_q     <= type_d;
      nostream_q <= ~stream_ok;
      lock_q     <= lock_d;
      loss_q     <= ~stream_ok & ~nostream_q;
      ret_q      <= stream_ok & nostream_q;
      lkev_q     <= lock_d ^ lock_q;
    end
  end

  assign nostream_o = nostream_q;
  assign lock_o     = lock_q;
  assign loss_evt_o = loss_q;
  assign ret_evt_o  = ret_q;
  assign lock_evt_o = lkev_q;

  // R3: a missing stream always clears lock at the next edge
  p_lock_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_ok |=> !lock_o);
  // R6: a falling stream flag yields a loss event one edge later
  p_loss_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stream_ok) |=> loss_evt_o);
  // R6: loss and return events never coincide
  p_evt_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(loss_evt_o && ret_evt_o));
endmodule

// File: rtl/fade_chan.sv
module fade_chan
  import stream_mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int FRAC_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  chan_ctl_t           ctl,
  input  logic [SAMPLE_W-1:0] samp_i,
  output logic [SAMPLE_W-1:0] samp_o
);
  localparam int ACC_W = SAMPLE_W + FRAC_W;

  logic [SAMPLE_W-1:0] last_q, last_d, out_q, out_d;
  logic [ACC_W-1:0]    acc_q, acc_d, acc_step, last_ext, acc_load;

  assign last_ext = {{FRAC_W{last_q[SAMPLE_W-1]}}, last_q};
  assign acc_load = {last_q, {FRAC_W{1'b0}}};
  assign acc_step = acc_q - last_ext;

  always_comb begin
    last_d = last_q;
    acc_d  = acc_q;
    out_d  = out_q;
    if (ctl.pass_en) begin
      last_d = samp_i;
      out_d  = samp_i;
    end
    if (ctl.fade_load) acc_d = acc_load;
    if (ctl.fade_step) begin
      acc_d = acc_step;
      out_d = acc_step[ACC_W-1:FRAC_W];
    end
    if (ctl.force_zero) out_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      acc_q  <= '0;
      out_q  <= '0;
    end else begin
      last_q <= last_d;
      acc_q  <= acc_d;
      out_q  <= out_d;
    end
  end

  assign samp_o = out_q;

  // R4: the final ramp step lands exactly on zero
  p_fade_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.fade_last |=> (acc_q == '0) && (out_q == '0));
  // R4: a non-negative ramp never rises and never changes sign
  p_fade_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fade_step && !last_q[SAMPLE_W-1]) |=>
      (!out_q[SAMPLE_W-1] && ($signed(out_q) <= $past($signed(out_q)))));
  // R5: forced silence shows at the output one edge later
  p_zero_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.force_zero |=> (out_q == '0));
endmodule

// File: rtl/stream_mute_ctrl.sv
module stream_mute_ctrl
  import stream_mute_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int FADE_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic                stream_ok,
  input  logic                lock_in,
  input  logic                non_audio,
  input  logic [SAMPLE_W-1:0] samp_a_i,
  input  logic [SAMPLE_W-1:0] samp_b_i,
  output logic [SAMPLE_W-1:0] samp_a_o,
  output logic [SAMPLE_W-1:0] samp_b_o,
  output logic                nostream_o,
  output logic                lock_o,
  output logic                loss_evt_o,
  output logic                ret_evt_o,
  output logic                lock_evt_o
);
  localparam int NCH = 2;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  chan_ctl_t           ctl;
  logic [SAMPLE_W-1:0] s_in  [NCH];
  logic [SAMPLE_W-1:0] s_out [NCH];

  assign s_in[0]  = samp_a_i;
  assign s_in[1]  = samp_b_i;
  assign samp_a_o = s_out[0];
  assign samp_b_o = s_out[1];

  mute_seq #(.FADE_LOG2(FADE_LOG2)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_stb  (frame_stb),
    .stream_ok  (stream_ok),
    .lock_in    (lock_in),
    .non_audio  (non_audio),
    .ctl        (ctl),
    .nostream_o (nostream_o),
    .lock_o     (lock_o),
    .loss_evt_o (loss_evt_o),
    .ret_evt_o  (ret_evt_o),
    .lock_evt_o (lock_evt_o)
  );

  // R8: one independent ramp engine per channel
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    fade_chan #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FADE_LOG2)) u_chan (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ctl    (ctl),
      .samp_i (s_in[g]),
      .samp_o (s_out[g])
    );
  end
endmodule

// File: tb/sim_stream_mute_ctrl.sv
module sim_stream_mute_ctrl;
  logic clk = 1'b0;
  logic rst_n, frame_stb, stream_ok, lock_in, non_audio;
  logic [23:0] a_i, b_i, a_o, b_o;
  logic nostream_o, lock_o, loss_evt_o, ret_evt_o, lock_evt_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stream_mute_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .stream_ok(stream_ok),
    .lock_in(lock_in), .non_audio(non_audio), .samp_a_i(a_i), .samp_b_i(b_i),
    .samp_a_o(a_o), .samp_b_o(b_o), .nostream_o(nostream_o), .lock_o(lock_o),
    .loss_evt_o(loss_evt_o), .ret_evt_o(ret_evt_o), .lock_evt_o(lock_evt_o)
  );

  localparam logic [47:0] VEC [6] = '{
    48'h000001_FFFFFF, 48'h7FFFFF_800000, 48'h123456_ABCDEF,
    48'h800001_7FFFFE, 48'h000000_000000, 48'h5A5A5A_A5A5A5
  };

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(logic [23:0] a, logic [23:0] b);
    a_i = a; b_i = b; frame_stb = 1'b1;
    step();
    frame_stb = 1'b0;
  endtask

  function automatic logic [23:0] fexp(logic [23:0] l, int k);
    longint num, q;
    num = longint'($signed(l)) * longint'(4096 - k);
    q = num / 4096;
    if (num < 0 && (num % 4096) != 0) q = q - 1;
    return q[23:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] la, lb;
    rst_n = 1'b0; frame_stb = 1'b0; stream_ok = 1'b0; lock_in = 1'b0;
    non_audio = 1'b0; a_i = '0; b_i = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 samples", {a_o, b_o}, 48'h0);
    chk("R1 status", {43'h0, nostream_o, lock_o, loss_evt_o, ret_evt_o, lock_evt_o},
        {43'h0, 5'b10000});
    rst_n = 1'b1;
    repeat (4) step();

    // bring the stream up
    stream_ok = 1'b1; lock_in = 1'b1;
    step();
    chk("R3 R6 return", {43'h0, nostream_o, lock_o, loss_evt_o, ret_evt_o, lock_evt_o},
        {43'h0, 5'b01011});
    step();
    chk("R6 pulse ends", {46'h0, ret_evt_o, lock_evt_o}, 48'h0);

    // R2 table walk
    foreach (VEC[i]) begin
      frame(VEC[i][47:24], VEC[i][23:0]);
      chk("R2 pass", {a_o, b_o}, VEC[i]);
    end
    a_i = 24'h111111; b_i = 24'h222222;
    step(); step();
    chk("R2 hold", {a_o, b_o}, VEC[5]);

    // R4 R8 PCM ramp, opposite signs
    la = 24'h400123; lb = 24'hD0FF5F;
    frame(la, lb);
    stream_ok = 1'b0;
    step();
    chk("R3 R6 loss", {43'h0, nostream_o, lock_o, loss_evt_o, ret_evt_o, lock_evt_o},
        {43'h0, 5'b10101});
    chk("R4 start", {a_o, b_o}, {la, lb});
    step();
    chk("R6 loss pulse ends", {47'h0, loss_evt_o}, 48'h0);
    for (int k = 1; k <= 4096; k++) begin
      frame(24'h123456, 24'h654321);
      chk("R4 R8 ramp", {a_o, b_o}, {fexp(la, k), fexp(lb, k)});
    end
    frame(24'h0F0F0F, 24'h0F0F0F);
    chk("R4 stays zero", {a_o, b_o}, 48'h0);

    // lock returns, live again
    stream_ok = 1'b1;
    step(); step();
    frame(24'h00ABCD, 24'hFF0001);
    chk("R7 live after lock", {a_o, b_o}, 48'h00ABCD_FF0001);

    // R5 non-PCM loss
    non_audio = 1'b1;
    frame(24'h3C3C3C, 24'hC3C3C3);
    chk("R2 non-PCM pass", {a_o, b_o}, 48'h3C3C3C_C3C3C3);
    stream_ok = 1'b0;
    step();
    chk("R5 immediate zero", {a_o, b_o}, 48'h0);
    frame(24'h777777, 24'h777777);
    chk("R5 held zero", {a_o, b_o}, 48'h0);

    // R7 return during ramp
    stream_ok = 1'b1; non_audio = 1'b0;
    step(); step();
    la = 24'h7FFFFF; lb = 24'h800000;
    frame(la, lb);
    stream_ok = 1'b0;
    step();
    for (int k = 1; k <= 100; k++) frame(24'h0, 24'h0);
    chk("R4 R8 ramp k100", {a_o, b_o}, {fexp(la, 100), fexp(lb, 100)});
    stream_ok = 1'b1; lock_in = 1'b0;
    frame(24'h111111, 24'h222222);
    frame(24'h111111, 24'h222222);
    chk("R7 muted without lock", {a_o, b_o}, {fexp(la, 102), fexp(lb, 102)});
    chk("R3 no lock", {47'h0, lock_o}, 48'h0);
    lock_in = 1'b1;
    step();
    chk("R3 lock back", {46'h0, lock_o, lock_evt_o}, {46'h0, 2'b11});
    step();
    frame(24'h0A0B0C, 24'hF0F1F2);
    chk("R7 live after return", {a_o, b_o}, 48'h0A0B0C_F0F1F2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule